// File: doc/BRIEF.md
# Shared-Period Toggle PWM Generator

The block drives a vector of output pins from a small pool of PWM slots that share one 16-bit up-counter. A period compare register clears the counter when it matches. Each slot has its own compare register. The slot's pin toggles on that compare and toggles again on the period match, so the waveform comes from match events and not from a level comparison.

Software-style requests arrive on a valid/ready port. Each request carries an output pin index, a period and a pulse width. The block looks up a slot for the pin and refuses a period that disagrees with the one already running on another active pin. It then either starts toggling or parks the pin at a static level. One cycle after acceptance a 2-bit status comes back. The counter prescaler is a fixed parameter.

Top module: `tpwm_top`

## Requirements
- R1: After reset every bit of `pin_o` is low, `req_ready_o` is high, `rsp_valid_o` is low and all slots are empty.
- R2: A request is taken when `req_valid_i` and `req_ready_o` are both high. In the next cycle `rsp_valid_o` is high for exactly one cycle and `req_ready_o` is low. `rsp_status_o` encodes 0 = ok, 1 = period conflict, 2 = no slot.
- R3: An accepted toggling request sets `pin_o[req_pin_i]` high in the cycle after acceptance and restarts the counter from 0. With `PRESC_LOG2` = 0 the counter advances once per clock. The pin is then high for scaled pulse + 1 clocks and low until a full period of scaled period + 1 clocks has passed, and this repeats.
- R4: The scaling shift s is the smallest value for which period >> s is below 2^16. The pulse and the period are both shifted right by s before they are loaded into the compare registers.
- R5: A pulse of 0 drives the pin low. A pulse equal to the period drives it high. In both cases the slot becomes inactive and the pin holds its level.
- R6: A toggling request gets status 1 and changes nothing when another pin's slot is active and the request's period differs from the running period. Static requests skip this check.
- R7: Slot lookup first takes the lowest slot whose stored pin equals the request's pin. Failing that, it takes the highest slot that is inactive. If neither exists, the status is 2 and nothing changes. This holds for static requests too.
- R8: When a request leaves every slot inactive, the counter stops and all pins hold their level.
- R9: All active slots share the period match, so their pins toggle in the same cycle when the counter wraps.
- R10: A request that retunes an active slot suppresses that slot's toggle in the reload cycle and restarts its waveform high from counter zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_pin_i | input | PIN_W | Output pin index |
| req_period_i | input | REQ_W | Period in counter ticks before scaling |
| req_pulse_i | input | REQ_W | High time in counter ticks before scaling |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_status_o | output | 2 | 0 ok, 1 period conflict, 2 no slot |
| pin_o | output | 2**PIN_W | Pin levels |

## Verification
The hardest state to reach is a full slot table that meets a request for a new pin, since that needs every slot active at one common period. The stimulus first fills all slots on one period, then sends a toggling request and a static request for an unused pin. It then sends a conflicting period. A scaled period above 16 bits, followed by a retune of the same active slot in mid-waveform, covers the shift and the reload suppression. A behavioural model in the bench tracks every pin on every clock.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_CONFLICT = 2'd1,
    ST_NOSLOT   = 2'd2
  } status_e;
endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase #(
  parameter int CNT_W      = 16,
  parameter int PRESC_LOG2 = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] per_cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             per_hit_o,
  output logic             run_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_done;

  generate
    if (PRESC_LOG2 == 0) begin : g_nopre
      assign pre_done = 1'b1;
    end else begin : g_pre
      logic [PRESC_LOG2-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (start_i) pre_q <= '0;
        else if (run_q)   pre_q <= pre_q + 1'b1;
      end
      assign pre_done = &pre_q;
    end
  endgenerate

  assign tick_o    = run_q & pre_done;
  assign per_hit_o = tick_o && (cnt_q == per_cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= per_hit_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tpwm_chan.sv
module tpwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             per_hit_i,
  output logic             toggle_o
);
  logic             active_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmp_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cmp_q    <= cmp_i;
    end else if (clear_i) begin
      active_q <= 1'b0;
    end
  end

  // reload or clear in flight masks the old toggle
  assign toggle_o = active_q & ~load_i & ~clear_i &
                    ((tick_i & (cnt_i == cmp_q)) ^ per_hit_i);
endmodule

// File: rtl/tpwm_alloc.sv
module tpwm_alloc #(
  parameter int N_CH   = 3,
  parameter int PIN_W  = 4,
  parameter int REQ_W  = 20,
  parameter int SLOT_W = 2
) (
  input  logic [N_CH-1:0][PIN_W-1:0] slot_pin_i,
  input  logic [N_CH-1:0]            busy_i,
  input  logic [REQ_W-1:0]           run_period_i,
  input  logic [PIN_W-1:0]           req_pin_i,
  input  logic [REQ_W-1:0]           req_period_i,
  input  logic                       is_static_i,
  output logic [SLOT_W-1:0]          slot_o,
  output logic                       found_o,
  output logic                       conflict_o,
  output logic                       others_busy_o
);
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (!found_o && slot_pin_i[i] == req_pin_i) begin
        found_o = 1'b1;
        slot_o  = SLOT_W'(i);
      end
    end
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (!found_o && !busy_i[i]) begin
        found_o = 1'b1;
        slot_o  = SLOT_W'(i);
      end
    end
    conflict_o = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (!is_static_i && busy_i[i] && slot_pin_i[i] != req_pin_i &&
          req_period_i != run_period_i)
        conflict_o = 1'b1;
    end
    others_busy_o = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (busy_i[i] && SLOT_W'(i) != slot_o) others_busy_o = 1'b1;
    end
  end
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top #(
  parameter int N_CH       = 3,
  parameter int PIN_W      = 4,
  parameter int REQ_W      = 20,
  parameter int CNT_W      = 16,
  parameter int PRESC_LOG2 = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [PIN_W-1:0]      req_pin_i,
  input  logic [REQ_W-1:0]      req_period_i,
  input  logic [REQ_W-1:0]      req_pulse_i,
  output logic                  rsp_valid_o,
  output logic [1:0]            rsp_status_o,
  output logic [(1<<PIN_W)-1:0] pin_o
);
  import tpwm_pkg::*;

  localparam int N_PIN  = 1 << PIN_W;
  localparam int SLOT_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int SH_W   = $clog2(REQ_W + 1);

  logic [N_CH-1:0][PIN_W-1:0] slot_pin_q;
  logic [N_CH-1:0][REQ_W-1:0] slot_pulse_q;
  logic [N_CH-1:0]            busy;
  logic [REQ_W-1:0]           run_period_q;
  logic [CNT_W-1:0]           per_cmp_q;
  logic [N_PIN-1:0]           pin_q, pin_d;
  logic                       rsp_valid_q;
  status_e                    rsp_status_q;

  logic              acc, is_static, found, conflict, others_busy;
  logic              ok_tog, ok_stat;
  logic [SLOT_W-1:0] slot_sel;
  logic [SH_W-1:0]   sh;
  logic [CNT_W-1:0]  per_sc, pulse_sc, cnt;
  logic              tick, per_hit, run;
  logic [N_CH-1:0]   tog;

  assign req_ready_o = ~rsp_valid_q;
  assign acc         = req_valid_i & req_ready_o;
  assign is_static   = (req_pulse_i == '0) || (req_pulse_i == req_period_i);
  assign ok_tog      = acc & found & ~conflict & ~is_static;
  assign ok_stat     = acc & found & ~conflict & is_static;

  for (genvar i = 0; i < N_CH; i++) begin : g_busy
    assign busy[i] = |slot_pulse_q[i];
  end

  // smallest shift that brings the period into the counter width
  always_comb begin
    logic fnd;
    fnd = 1'b0;
    sh  = '0;
    for (int s = 0; s <= REQ_W; s++) begin
      if (!fnd && ((req_period_i >> s) >> CNT_W) == '0) begin
        fnd = 1'b1;
        sh  = SH_W'(s);
      end
    end
  end
  assign per_sc   = CNT_W'(req_period_i >> sh);
  assign pulse_sc = CNT_W'(req_pulse_i >> sh);

  tpwm_alloc #(.N_CH(N_CH), .PIN_W(PIN_W), .REQ_W(REQ_W), .SLOT_W(SLOT_W)) u_alloc (
    .slot_pin_i   (slot_pin_q),
    .busy_i       (busy),
    .run_period_i (run_period_q),
    .req_pin_i    (req_pin_i),
    .req_period_i (req_period_i),
    .is_static_i  (is_static),
    .slot_o       (slot_sel),
    .found_o      (found),
    .conflict_o   (conflict),
    .others_busy_o(others_busy)
  );

  tpwm_timebase #(.CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ok_tog),
    .stop_i   (ok_stat & ~others_busy),
    .per_cmp_i(per_cmp_q),
    .cnt_o    (cnt),
    .tick_o   (tick),
    .per_hit_o(per_hit),
    .run_o    (run)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tpwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (ok_tog && slot_sel == SLOT_W'(i)),
      .clear_i  (ok_stat && slot_sel == SLOT_W'(i)),
      .cmp_i    (pulse_sc),
      .cnt_i    (cnt),
      .tick_i   (tick),
      .per_hit_i(per_hit),
      .toggle_o (tog[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_pin_q   <= '0;
      slot_pulse_q <= '0;
      run_period_q <= '0;
      per_cmp_q    <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (slot_sel == SLOT_W'(i)) begin
          if (ok_tog) begin
            slot_pin_q[i]   <= req_pin_i;
            slot_pulse_q[i] <= req_pulse_i;
          end else if (ok_stat) begin
            slot_pulse_q[i] <= '0;
          end
        end
      end
      if (ok_tog) begin
        run_period_q <= req_period_i;
        per_cmp_q    <= per_sc;
      end
    end
  end

  always_comb begin
    pin_d = pin_q;
    for (int c = 0; c < N_CH; c++)
      if (tog[c]) pin_d[slot_pin_q[c]] = ~pin_d[slot_pin_q[c]];
    if (ok_tog)       pin_d[req_pin_i] = 1'b1;
    else if (ok_stat) pin_d[req_pin_i] = |req_pulse_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q        <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
    end else begin
      pin_q       <= pin_d;
      rsp_valid_q <= acc;
      if (acc) rsp_status_q <= conflict ? ST_CONFLICT : (found ? ST_OK : ST_NOSLOT);
    end
  end

  assign pin_o        = pin_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_status_o = rsp_status_q;
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
  parameter int N_CH  = 3,
  parameter int N_PIN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_status_o,
  input logic [N_PIN-1:0] pin_o,
  input logic             run_i,
  input logic [N_CH-1:0]  busy_i
);
  a_r2_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  a_r2_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_status_o != 2'd3);

  a_r7_noslot_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd2) |-> &busy_i);

  a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd0 && busy_i == '0) |-> !run_i);

  a_r8_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !(req_valid_i && req_ready_o)) |=> $stable(pin_o));
endmodule

bind tpwm_top tpwm_chk #(.N_CH(N_CH), .N_PIN(N_PIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .pin_o       (pin_o),
  .run_i       (run),
  .busy_i      (busy)
);

// File: tb/sim_tpwm_top.sv
module sim_tpwm_top;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_pin = '0;
  logic [19:0] req_period = '0;
  logic [19:0] req_pulse = '0;
  logic        req_ready, rsp_valid;
  logic [1:0]  rsp_status;
  logic [15:0] pin_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tpwm_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pin_i(req_pin), .req_period_i(req_period), .req_pulse_i(req_pulse),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .pin_o(pin_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pin[NC], m_pul[NC], m_cmp[NC];
  int m_per, m_pcmp, m_cnt, m_st;
  bit m_run, m_rv;
  bit [15:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    bit acc, evp, stat, conf;
    bit [15:0] nxt;
    int slot, sh, pin, per, pul;
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_pin[i] = 0; m_pul[i] = 0; m_cmp[i] = 0; end
      m_per = 0; m_pcmp = 0; m_cnt = 0; m_st = 0; m_run = 0; m_rv = 0; m_out = '0;
    end else begin
      acc = req_valid && !m_rv;
      pin = int'(req_pin); per = int'(req_period); pul = int'(req_pulse);
      evp = m_run && m_cnt == m_pcmp;
      nxt = m_out;
      for (int i = 0; i < NC; i++)
        if (m_pul[i] != 0 && ((m_run && m_cnt == m_cmp[i]) ^ evp)) nxt[m_pin[i]] = ~nxt[m_pin[i]];
      if (m_run) m_cnt = evp ? 0 : m_cnt + 1;
      m_rv = acc;
      if (acc) begin
        stat = (pul == 0) || (pul == per);
        conf = 1'b0;
        if (!stat)
          for (int i = 0; i < NC; i++)
            if (m_pin[i] != pin && m_pul[i] != 0 && per != m_per) conf = 1'b1;
        slot = -1;
        for (int i = 0; i < NC; i++) if (slot < 0 && m_pin[i] == pin) slot = i;
        for (int i = NC - 1; i >= 0; i--) if (slot < 0 && m_pul[i] == 0) slot = i;
        if (conf) m_st = 1;
        else if (slot < 0) m_st = 2;
        else begin
          m_st = 0;
          if (stat) begin
            m_pul[slot] = 0;
            nxt[pin] = (pul != 0);
            if (m_pul[0] == 0 && m_pul[1] == 0 && m_pul[2] == 0) m_run = 1'b0;
          end else begin
            sh = 0;
            while ((per >> sh) >= 65536) sh++;
            m_cmp[slot] = pul >> sh; m_pcmp = per >> sh;
            m_cnt = 0; m_run = 1'b1;
            m_pin[slot] = pin; m_pul[slot] = pul; m_per = per;
            nxt[pin] = 1'b1;
          end
        end
      end
      m_out = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_o == m_out, "R3 pin vector vs model", pin_o, m_out);
      chk(rsp_valid == m_rv, "R2 rsp_valid vs model", rsp_valid, m_rv);
      chk(req_ready == !m_rv, "R2 ready vs model", req_ready, !m_rv);
      if (m_rv) chk(int'(rsp_status) == m_st, "R2 status vs model", rsp_status, m_st);
    end
  end

  task automatic send(input int pin, input int per, input int pul, input int exp_st, input string tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pin = 4'(pin); req_period = 20'(per); req_pulse = 20'(pul);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 response present", rsp_valid, 1);
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    chk(int'(rsp_status) == exp_st, tag, rsp_status, exp_st);
  endtask

  initial begin
    logic [15:0] prev;
    bit seen;
    repeat (3) @(negedge clk);
    chk(pin_o == '0, "R1 pins low in reset", pin_o, 0);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready high, no response", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_o == '0, "R1 pins low after reset", pin_o, 0);

    send(5, 10, 3, 0, "R3 start pin5");
    chk(pin_o[5] == 1'b1, "R3 pin5 high at start", pin_o[5], 1);
    repeat (3) @(negedge clk);
    chk(pin_o[5] == 1'b1, "R3 pin5 still high", pin_o[5], 1);
    @(negedge clk);
    chk(pin_o[5] == 1'b0, "R3 pin5 low after pulse", pin_o[5], 0);
    repeat (7) @(negedge clk);

    send(7, 12, 4, 1, "R6 period conflict");
    send(7, 10, 6, 0, "R7 pin7 takes free slot");
    seen = 1'b0;
    prev = pin_o;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (!prev[7] && pin_o[7]) begin
        seen = 1'b1;
        chk(pin_o[5] != prev[5], "R9 shared period toggles pin5 with pin7", pin_o[5], !prev[5]);
      end
      prev = pin_o;
    end
    chk(seen, "R9 pin7 wrap observed", seen, 1);

    send(5, 20, 5, 1, "R6 retune with conflicting period");
    send(9, 10, 2, 0, "R7 last free slot");
    send(11, 10, 4, 2, "R7 no slot toggling");
    send(11, 10, 0, 2, "R7 no slot for static request");
    repeat (5) @(negedge clk);

    send(7, 10, 10, 0, "R5 static high");
    chk(pin_o[7] == 1'b1, "R5 pin7 high", pin_o[7], 1);
    repeat (25) @(negedge clk);
    chk(pin_o[7] == 1'b1, "R5 pin7 holds high", pin_o[7], 1);

    send(0, 50, 25, 1, "R6 conflict with running period");
    send(5, 10, 0, 0, "R5 static low");
    chk(pin_o[5] == 1'b0, "R5 pin5 low", pin_o[5], 0);
    send(9, 99, 0, 0, "R6 static skips period check");
    repeat (40) @(negedge clk);
    chk(pin_o == 16'h0080, "R8 all idle, pins hold", pin_o, 16'h0080);

    send(0, 32'h20000, 40, 0, "R4 scaled start");
    chk(pin_o[0] == 1'b1, "R4 pin0 high", pin_o[0], 1);
    repeat (10) @(negedge clk);
    chk(pin_o[0] == 1'b1, "R4 pin0 high through scaled pulse", pin_o[0], 1);
    @(negedge clk);
    chk(pin_o[0] == 1'b0, "R4 pin0 low after pulse>>2", pin_o[0], 0);
    repeat (7) @(negedge clk);

    send(0, 32'h20000, 80, 0, "R10 retune active slot");
    chk(pin_o[0] == 1'b1, "R10 restart high", pin_o[0], 1);
    repeat (20) @(negedge clk);
    chk(pin_o[0] == 1'b1, "R10 high through new pulse", pin_o[0], 1);
    @(negedge clk);
    chk(pin_o[0] == 1'b0, "R10 low after new pulse", pin_o[0], 0);

    send(3, 32'h20000, 32'h20000, 0, "R5 static high on scaled period");
    chk(pin_o[3] == 1'b1, "R5 pin3 high", pin_o[3], 1);
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule